// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces refresh for a DRAM controller. A prescaler divides the system clock down to a 2 MHz tick, which gives a 500 ns tick period. An interval counter counts those ticks and closes one refresh interval every 30 ticks, about 15 µs. At the end of each interval the block raises a refresh request. The request stays up until the controller acknowledges it. Each acknowledge also advances the row address that the next refresh cycle will use.

Software or a board-level supervisor can restart the whole timing chain. It does so by holding the refresh-inhibit input low while driving the external refresh strobe high, and the strobe must be seen high on a tick boundary. This zeroes the prescaler, the interval counter and the row address, and it drops any pending request. Counting restarts only when the strobe is released, so the next internal request comes one full interval after the release. While the inhibit input is high, no new request is raised, but the timer keeps its phase.

Top module: `rfsh_req_timer`

## Requirements
- R1: While `rst` is high and right after it, `refresh_req` is 0 and `row_addr` is 0.
- R2: The first `refresh_req` rises exactly CLK_DIV*INTERVAL_TICKS clock edges after reset is released. The first edge that samples `rst` low counts as edge 1.
- R3: `refresh_req` stays high until it is acknowledged. It is 0 in the cycle after an edge that samples `refresh_ack` high while the request is up.
- R4: Each acknowledge of a pending request increments `row_addr` by one, modulo 2^ROW_W. An `refresh_ack` with no request pending leaves `row_addr` unchanged.
- R5: The interval timer runs freely. Requests rise every CLK_DIV*INTERVAL_TICKS edges, whenever the previous request was acknowledged.
- R6: While `refresh_inhibit` is high, no new request is raised. The interval timer keeps counting, so the next request after the inhibit is released still falls on the original interval grid.
- R7: A tick edge that samples `ext_refresh` high and `refresh_inhibit` low clears the timer. After that edge, `row_addr` is 0 and `refresh_req` is 0, even if a request was pending.
- R8: After a clear, the timer stays at zero while `ext_refresh` remains high. The next request rises exactly CLK_DIV*INTERVAL_TICKS edges after release, counting the first edge that samples `ext_refresh` low as edge 1.
- R9: `ext_refresh` held high while `refresh_inhibit` is also high causes no clear. The row address and the interval phase are kept.
- R10: An `ext_refresh` pulse that is not high on any tick edge causes no clear. The row address and the interval phase are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_inhibit | input | 1 | High: suppress new refresh requests; also qualifies the clear |
| ext_refresh | input | 1 | External refresh strobe; with inhibit low, clears the timer |
| refresh_ack | input | 1 | Controller acknowledge of the pending request |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| row_addr | output | ROW_W | Row address for the next refresh |

## Verification
The bench counts edges exactly at each interval boundary, one cycle before the expected rise and on it. An off-by-one in the prescaler or in the interval terminal count therefore shows up as an early or late request. It checks that a clear holds the timer until the strobe is released. A design that restarted counting on the clearing edge itself would raise its request too early. Strobes given with inhibit high, or too short to cover a tick edge, must leave the row address and the interval phase intact; a design that cleared on them would show a zero row or a shifted request. An inhibit spanning a boundary must suppress exactly one request without shifting the grid, and eight acknowledges with a three-bit row must wrap the address back to zero.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic {
    CLR_IDLE = 1'b0,
    CLR_HOLD = 1'b1
  } clr_state_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic zero,
  output logic tick
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      div_cnt <= '0;
    end else if (div_cnt == LAST) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int INTERVAL_TICKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic zero,
  input  logic tick,
  output logic done
);
  localparam int IW = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL_TICKS - 1);

  logic [IW-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      tick_cnt <= '0;
    end else if (tick) begin
      if (tick_cnt == LAST) begin
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assign done = tick && (tick_cnt == LAST) && !zero;
endmodule

// File: rtl/row_addr_counter.sv
module row_addr_counter #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
    end else if (inc) begin
      row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer #(
  parameter int CLK_DIV        = 8,
  parameter int INTERVAL_TICKS = 30,
  parameter int ROW_W          = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refresh_inhibit,
  input  logic             ext_refresh,
  input  logic             refresh_ack,
  output logic             refresh_req,
  output logic [ROW_W-1:0] row_addr
);
  import rfsh_pkg::*;

  initial begin
    if (CLK_DIV < 2) $error("CLK_DIV must be at least 2");
    if (INTERVAL_TICKS < 2) $error("INTERVAL_TICKS must be at least 2");
  end

  clr_state_t clr_state;
  logic       clear_armed;
  logic       tick;
  logic       interval_done;
  logic       clr_start;
  logic       zero_timers;
  logic       ack_take;

  assign clear_armed = (clr_state == CLR_HOLD);
  assign clr_start   = tick && ext_refresh && !refresh_inhibit && !clear_armed;
  assign zero_timers = clr_start || (clear_armed && ext_refresh);
  assign ack_take    = refresh_req && refresh_ack && !clr_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_state <= CLR_IDLE;
    end else begin
      case (clr_state)
        CLR_IDLE: if (clr_start)    clr_state <= CLR_HOLD;
        CLR_HOLD: if (!ext_refresh) clr_state <= CLR_IDLE;
        default:                    clr_state <= CLR_IDLE;
      endcase
    end
  end

  tick_prescaler #(.CLK_DIV(CLK_DIV)) u_prescaler (
    .clk  (clk),
    .rst  (rst),
    .zero (zero_timers),
    .tick (tick)
  );

  interval_counter #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .zero (zero_timers),
    .tick (tick),
    .done (interval_done)
  );

  row_addr_counter #(.ROW_W(ROW_W)) u_row (
    .clk (clk),
    .rst (rst),
    .clr (clr_start),
    .inc (ack_take),
    .row (row_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || zero_timers) begin
      refresh_req <= 1'b0;
    end else if (interval_done && !refresh_inhibit) begin
      refresh_req <= 1'b1;
    end else if (ack_take) begin
      refresh_req <= 1'b0;
    end
  end
endmodule

// File: rtl/rfsh_req_timer_chk.sv
module rfsh_req_timer_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             refresh_inhibit,
  input logic             ext_refresh,
  input logic             refresh_ack,
  input logic             refresh_req,
  input logic [ROW_W-1:0] row_addr,
  input logic             clear_armed
);
  a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
    refresh_req && !refresh_ack && !ext_refresh |=> refresh_req);

  a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
    refresh_req && refresh_ack && !ext_refresh |=> row_addr == ROW_W'($past(row_addr) + 1'b1));

  a_r4_row_idle: assert property (@(posedge clk) disable iff (rst)
    !(refresh_req && refresh_ack) && !ext_refresh |=> $stable(row_addr));

  a_r6_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
    !refresh_req && refresh_inhibit |=> !refresh_req);

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(clear_armed) |-> (row_addr == '0) && !refresh_req);

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    clear_armed |=> !refresh_req);
endmodule

bind rfsh_req_timer rfsh_req_timer_chk #(.ROW_W(ROW_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .refresh_inhibit (refresh_inhibit),
  .ext_refresh     (ext_refresh),
  .refresh_ack     (refresh_ack),
  .refresh_req     (refresh_req),
  .row_addr        (row_addr),
  .clear_armed     (clear_armed)
);

// File: tb/rfsh_req_timer_bench.sv
module rfsh_req_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int TCK  = 30;
  localparam int RW   = 3;
  localparam int N    = DIV * TCK;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inhibit = 1'b0;
  logic          ext = 1'b0;
  logic          ack = 1'b0;
  logic          req;
  logic [RW-1:0] row;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_req_timer #(.CLK_DIV(DIV), .INTERVAL_TICKS(TCK), .ROW_W(RW)) u_rfsh_req_timer (
    .clk             (clk),
    .rst             (rst),
    .refresh_inhibit (inhibit),
    .ext_refresh     (ext),
    .refresh_ack     (ack),
    .refresh_req     (req),
    .row_addr        (row)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  // edges since reset release: tracked by each task
  task automatic t_reset();
    rst = 1'b1;
    step(3);
    chk(req == 1'b0, "R1 req", req, 0);
    chk(row == 0, "R1 row", row, 0);
    rst = 1'b0;
  endtask

  task automatic t_first_and_hold();
    step(N - 1);
    chk(req == 1'b0, "R2 before", req, 0);
    step(1);
    chk(req == 1'b1, "R2 rise", req, 1);
    step(5);
    chk(req == 1'b1, "R3 held", req, 1);
    do_ack();
    chk(req == 1'b0, "R3 drop", req, 0);
    chk(row == 1, "R4 inc", row, 1);
  endtask

  task automatic t_period();
    step(N - 7);
    chk(req == 1'b0, "R5 before", req, 0);
    step(1);
    chk(req == 1'b1, "R5 rise", req, 1);
    do_ack();
    chk(row == 2, "R4 inc2", row, 2);
    do_ack();
    chk(row == 2, "R4 idle ack", row, 2);
  endtask

  task automatic t_inhibit();
    inhibit = 1'b1;
    step(N);
    chk(req == 1'b0, "R6 suppressed", req, 0);
    inhibit = 1'b0;
    step(N - 3);
    chk(req == 1'b0, "R6 before", req, 0);
    step(1);
    chk(req == 1'b1, "R6 grid kept", req, 1);
    do_ack();
    chk(row == 3, "R6 row", row, 3);
  endtask

  task automatic t_no_clear_inhibit();
    inhibit = 1'b1;
    ext = 1'b1;
    step(DIV + 1);
    ext = 1'b0;
    inhibit = 1'b0;
    chk(row == 3, "R9 row kept", row, 3);
    step(N - DIV - 3);
    chk(req == 1'b0, "R9 before", req, 0);
    step(1);
    chk(req == 1'b1, "R9 phase kept", req, 1);
    do_ack();
  endtask

  task automatic t_short_pulse();
    ext = 1'b1;
    step(1);
    ext = 1'b0;
    chk(row == 4, "R10 row kept", row, 4);
    step(N - 3);
    chk(req == 1'b0, "R10 before", req, 0);
    step(1);
    chk(req == 1'b1, "R10 phase kept", req, 1);
    do_ack();
    chk(row == 5, "R10 row5", row, 5);
  endtask

  task automatic t_clear();
    ext = 1'b1;
    step(DIV);
    chk(row == 0, "R7 row zero", row, 0);
    chk(req == 1'b0, "R7 req low", req, 0);
    step(10);
    ext = 1'b0;
    step(N - 1);
    chk(req == 1'b0, "R8 before", req, 0);
    step(1);
    chk(req == 1'b1, "R8 rise", req, 1);
    ext = 1'b1;
    step(DIV);
    chk(req == 1'b0, "R7 pending dropped", req, 0);
    chk(row == 0, "R7 row zero2", row, 0);
    ext = 1'b0;
    step(N);
    chk(req == 1'b1, "R8 rise2", req, 1);
    do_ack();
    chk(row == 1, "R4 after clear", row, 1);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 7; k++) begin
      step(N - 1);
      chk(req == 1'b1, "R5 loop rise", req, 1);
      do_ack();
    end
    chk(row == 0, "R4 wrap", row, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_first_and_hold();
    t_period();
    t_inhibit();
    t_no_clear_inhibit();
    t_short_pulse();
    t_clear();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule